// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block is a single user I/O cell placed between a package pad and the core logic. A 3-bit configuration field picks what the cell does. It can pass the pad through combinationally, capture it in a register, or hold it in a level-sensitive latch. It can also drive the pad as an output only, or work as a bidirectional pin whose tri-state driver is gated by an enable signal. That enable is shared across a group of sixteen cells. A single configuration bit selects the polarity of the driven value.

Registered and latched capture take their timing from one of two I/O clock lines, and a select input picks the line. The cell runs on a single system clock `clk_i`, and it treats the I/O clock lines as sampled level signals. The register captures the pad value on the first `clk_i` edge at which the selected line is seen high after being low. The latch follows the pad on every `clk_i` edge while the selected line is high and holds while it is low. An active-low asynchronous reset clears both storage elements.

A feedback output returns the value on the pin to the core. That value is the driven value while the driver is enabled and the pad value otherwise.

Top module: `io_cell`

## Requirements
- R1: `cfg_mode_i` encodings are 0 = combinational input, 1 = registered input, 2 = latched input, 3 = output only, 4 = bidirectional. Encodings 5, 6 and 7 behave exactly as encoding 0.
- R2: In combinational input, output only and bidirectional modes, `core_q_o` equals `pad_i` in the same cycle.
- R3: In registered mode, `core_q_o` takes the value of `pad_i` at the first `clk_i` rising edge at which the selected I/O clock line is high after having been low at the previous edge. At every other edge it holds its value.
- R4: In latched mode, `core_q_o` takes `pad_i` at each `clk_i` rising edge at which the selected I/O clock line is high, and holds while that line is low.
- R5: `clk_sel_i` = 0 selects `ioclk_i[0]` and `clk_sel_i` = 1 selects `ioclk_i[1]`. Activity on the line that is not selected leaves the captured value unchanged.
- R6: `pad_o` equals `core_d_i` when `cfg_inv_i` = 0 and equals its inverse when `cfg_inv_i` = 1.
- R7: `pad_oe_o` is 0 in every input mode (encodings 0, 1, 2, 5, 6, 7) and is 1 in output only mode, whatever the value of `grp_oe_i`.
- R8: In bidirectional mode, `pad_oe_o` follows `grp_oe_i`.
- R9: `fb_o` equals `pad_o` while `pad_oe_o` = 1 and equals `pad_i` while `pad_oe_o` = 0.
- R10: While `rst_ni` is low, the capture register and the latch are held at 0 without waiting for a clock edge. As a result, `core_q_o` reads 0 in registered and latched modes during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 3 | Cell mode field |
| cfg_inv_i | input | 1 | Invert the driven value |
| clk_sel_i | input | 1 | I/O clock line select |
| ioclk_i | input | 2 | I/O clock lines, sampled as levels |
| grp_oe_i | input | 1 | Output enable shared by the cell group |
| core_d_i | input | 1 | Data from core to drive on the pad |
| core_q_o | output | 1 | Pad data delivered to the core |
| fb_o | output | 1 | Pin value fed back to the core |
| pad_i | input | 1 | Value seen at the pad |
| pad_o | output | 1 | Value driven to the pad |
| pad_oe_o | output | 1 | Pad driver enable |

## Verification
Some rules hold on every cycle, and the assertions check them continuously. These are the driver-enable rules for the input, output-only and bidirectional modes, the pad-following feedback while the bidirectional driver is off, and the combinational input path. The assertions also check the per-edge update and hold rules of the capture register and the latch. Other behaviours only show up in a planned stimulus sequence, so the bench scenarios cover them. Among them: holding a captured value across a long high level, ignoring the unselected clock line, aliasing of the unused mode encodings, both output polarities, and clearing of stored data on reset.

// File: rtl/io_cell_pkg.sv
package io_cell_pkg;

  typedef enum logic [2:0] {
    MODE_IN_COMB  = 3'd0,
    MODE_IN_REG   = 3'd1,
    MODE_IN_LATCH = 3'd2,
    MODE_OUT      = 3'd3,
    MODE_BIDIR    = 3'd4
  } io_mode_e;

  typedef enum logic [1:0] {
    SRC_COMB  = 2'd0,
    SRC_REG   = 2'd1,
    SRC_LATCH = 2'd2
  } in_src_e;

  typedef struct packed {
    in_src_e src;
    logic    drv_force;  // driver always on
    logic    drv_group;  // driver follows group enable
  } io_ctrl_t;

endpackage

// File: rtl/io_cell_dec.sv
module io_cell_dec
  import io_cell_pkg::*;
(
  input  logic [2:0] mode_i,
  output io_ctrl_t   ctrl_o
);

  always_comb begin
    ctrl_o = '{src: SRC_COMB, drv_force: 1'b0, drv_group: 1'b0};
    case (mode_i)
      MODE_IN_REG:   ctrl_o.src = SRC_REG;
      MODE_IN_LATCH: ctrl_o.src = SRC_LATCH;
      MODE_OUT:      ctrl_o.drv_force = 1'b1;
      MODE_BIDIR:    ctrl_o.drv_group = 1'b1;
      default:       ctrl_o = '{src: SRC_COMB, drv_force: 1'b0, drv_group: 1'b0};
    endcase
  end

endmodule

// File: rtl/io_cell_capture.sv
module io_cell_capture #(
  parameter int NUM_CLK = 2,
  parameter int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CLK-1:0] ioclk_i,
  input  logic [SEL_W-1:0]   clk_sel_i,
  input  logic               pad_i,
  output logic               reg_q_o,
  output logic               lat_q_o
);

  logic [NUM_CLK-1:0] hit;
  logic               sel_lvl;
  logic               sel_prev;
  logic               sel_rise;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_sel
    assign hit[g] = ioclk_i[g] && (clk_sel_i == SEL_W'(g));
  end

  assign sel_lvl  = |hit;
  assign sel_rise = sel_lvl && !sel_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_prev <= 1'b0;
    else         sel_prev <= sel_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_q_o <= 1'b0;
    else if (sel_rise) reg_q_o <= pad_i;
  end

  // transparent while selected line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q_o <= 1'b0;
    else if (sel_lvl) lat_q_o <= pad_i;
  end

  // R3
  reg_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rise |=> reg_q_o == $past(pad_i));
  // R3
  reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_rise |=> $stable(reg_q_o));
  // R4
  lat_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_lvl |=> lat_q_o == $past(pad_i));
  // R4
  lat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_lvl |=> $stable(lat_q_o));

endmodule

// File: rtl/io_cell_drive.sv
module io_cell_drive
  import io_cell_pkg::*;
(
  input  io_ctrl_t ctrl_i,
  input  logic     core_d_i,
  input  logic     inv_i,
  input  logic     grp_oe_i,
  input  logic     pad_i,
  output logic     pad_o,
  output logic     pad_oe_o,
  output logic     fb_o
);

  assign pad_oe_o = ctrl_i.drv_force || (ctrl_i.drv_group && grp_oe_i);
  assign pad_o    = core_d_i ^ inv_i;
  assign fb_o     = pad_oe_o ? pad_o : pad_i;

endmodule

// File: rtl/io_cell.sv
module io_cell
  import io_cell_pkg::*;
#(
  parameter int NUM_CLK = 2,
  localparam int SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         cfg_mode_i,
  input  logic               cfg_inv_i,
  input  logic [SEL_W-1:0]   clk_sel_i,
  input  logic [NUM_CLK-1:0] ioclk_i,
  input  logic               grp_oe_i,
  input  logic               core_d_i,
  output logic               core_q_o,
  output logic               fb_o,
  input  logic               pad_i,
  output logic               pad_o,
  output logic               pad_oe_o
);

  io_ctrl_t ctrl;
  logic     reg_q;
  logic     lat_q;

  io_cell_dec u_dec (
    .mode_i (cfg_mode_i),
    .ctrl_o (ctrl)
  );

  io_cell_capture #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ioclk_i   (ioclk_i),
    .clk_sel_i (clk_sel_i),
    .pad_i     (pad_i),
    .reg_q_o   (reg_q),
    .lat_q_o   (lat_q)
  );

  io_cell_drive u_drv (
    .ctrl_i   (ctrl),
    .core_d_i (core_d_i),
    .inv_i    (cfg_inv_i),
    .grp_oe_i (grp_oe_i),
    .pad_i    (pad_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o),
    .fb_o     (fb_o)
  );

  always_comb begin
    case (ctrl.src)
      SRC_REG:   core_q_o = reg_q;
      SRC_LATCH: core_q_o = lat_q;
      default:   core_q_o = pad_i;
    endcase
  end

  logic in_only;
  assign in_only = (cfg_mode_i != MODE_OUT) && (cfg_mode_i != MODE_BIDIR);

  // R7
  in_mode_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_only |-> !pad_oe_o);
  // R7
  out_mode_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == MODE_OUT) |-> pad_oe_o);
  // R8
  bidir_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == MODE_BIDIR) |-> (pad_oe_o == grp_oe_i));
  // R9
  bidir_fb_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == MODE_BIDIR && !grp_oe_i) |-> (fb_o == pad_i));
  // R2
  comb_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == MODE_IN_COMB) |-> (core_q_o == pad_i));

endmodule

// File: tb/sim_io_cell.sv
module sim_io_cell;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       inv = 1'b0;
  logic [0:0] sel = 1'b0;
  logic [1:0] ioclk = 2'b00;
  logic       grp_oe = 1'b0;
  logic       core_d = 1'b0;
  logic       pad_in = 1'b0;
  logic       core_q, fb, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  io_cell u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(mode), .cfg_inv_i(inv),
    .clk_sel_i(sel), .ioclk_i(ioclk), .grp_oe_i(grp_oe), .core_d_i(core_d),
    .core_q_o(core_q), .fb_o(fb), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk(core_q, 1'b0, "R10 comb reset pad0");
    mode = 3'd1; #1;
    chk(core_q, 1'b0, "R10 reg reset");
    mode = 3'd2; #1;
    chk(core_q, 1'b0, "R10 latch reset");
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_comb();
    for (int m = 0; m < 8; m++) begin
      if (m == 1 || m == 2) continue;
      mode = 3'(m);
      pad_in = 1'b1; #1;
      chk(core_q, 1'b1, "R2 R1 comb path high");
      pad_in = 1'b0; #1;
      chk(core_q, 1'b0, "R2 R1 comb path low");
    end
  endtask

  task automatic t_reg();
    mode = 3'd1; sel = 1'b0; ioclk = 2'b00; pad_in = 1'b1;
    step();
    chk(core_q, 1'b0, "R3 no edge no capture");
    ioclk = 2'b01;
    step();
    chk(core_q, 1'b1, "R3 capture on rise");
    pad_in = 1'b0;
    step(); step();
    chk(core_q, 1'b1, "R3 hold while line high");
    ioclk = 2'b00; step();
    ioclk = 2'b10; step();
    chk(core_q, 1'b1, "R5 unselected line ignored reg");
    ioclk = 2'b11; step();
    chk(core_q, 1'b0, "R3 second rise captures");
    ioclk = 2'b00; pad_in = 1'b1; step();
    sel = 1'b1; ioclk = 2'b10; step();
    chk(core_q, 1'b1, "R5 line1 selected capture");
  endtask

  task automatic t_latch();
    mode = 3'd2; sel = 1'b1; ioclk = 2'b10; pad_in = 1'b1;
    step();
    chk(core_q, 1'b1, "R4 transparent high");
    pad_in = 1'b0; step();
    chk(core_q, 1'b0, "R4 transparent follows");
    ioclk = 2'b00; pad_in = 1'b1; step(); step();
    chk(core_q, 1'b0, "R4 hold when low");
    ioclk = 2'b01; step();
    chk(core_q, 1'b0, "R5 unselected line ignored latch");
  endtask

  task automatic t_drive();
    mode = 3'd3; grp_oe = 1'b0; core_d = 1'b1; inv = 1'b0; pad_in = 1'b0; #1;
    chk(pad_oe, 1'b1, "R7 output mode drives");
    chk(pad_out, 1'b1, "R6 noninverted");
    chk(fb, 1'b1, "R9 fb driven value");
    inv = 1'b1; #1;
    chk(pad_out, 1'b0, "R6 inverted");
    for (int m = 0; m < 8; m++) begin
      if (m == 3 || m == 4) continue;
      mode = 3'(m); grp_oe = 1'b1; #1;
      chk(pad_oe, 1'b0, "R7 input mode no drive");
    end
    mode = 3'd4; grp_oe = 1'b0; pad_in = 1'b1; core_d = 1'b1; inv = 1'b0; #1;
    chk(pad_oe, 1'b0, "R8 bidir oe low");
    chk(fb, 1'b1, "R9 fb pad when off");
    core_d = 1'b0; #1;
    chk(fb, 1'b1, "R9 fb ignores core_d when off");
    grp_oe = 1'b1; #1;
    chk(pad_oe, 1'b1, "R8 bidir oe high");
    chk(fb, 1'b0, "R9 fb driven when on");
  endtask

  task automatic t_reset_clear();
    mode = 3'd1; sel = 1'b0; ioclk = 2'b00; pad_in = 1'b1; step();
    ioclk = 2'b01; step();
    chk(core_q, 1'b1, "R3 captured before reset");
    #0.5 rst_n = 1'b0; #0.5;
    chk(core_q, 1'b0, "R10 async clear reg");
    mode = 3'd2; #0.5;
    chk(core_q, 1'b0, "R10 async clear latch");
    step(); rst_n = 1'b1; step();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1;
    t_reset();
    t_comb();
    t_reg();
    t_latch();
    t_drive();
    t_reset_clear();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule